// File: doc/BRIEF.md
# I2C Target Front End

This block is the receive side of a two-wire serial target. It samples the clock and data lines from outside the chip and resynchronizes them to the system clock. It decodes START, repeated START and STOP conditions and keeps a free/busy flag for the bus that other logic can read.

After each START it shifts in one address byte. It compares the upper seven bits with a device address. That address is a fixed four-bit class code followed by three strap pins, so up to eight copies of the same target can share one bus. When the address matches, the block acknowledges it and reports the transfer direction. In a write, each received byte is acknowledged and handed to local logic with a one-cycle strobe. In a read, the block fetches bytes from local logic and shifts them out until the controller answers with a NACK.

The data line is never driven high. The block only outputs an active-low pull-down enable, which models an open-drain pad.

Top module: `i2c_target_fe`

## Requirements
- R1: After reset, `sda_pd_no` is 1 (released), `bus_busy_o`, `addr_match_o`, `wr_valid_o` and `rd_req_o` are 0.
- R2: A falling SDA while SCL is high (START) sets `bus_busy_o` to 1.
- R3: A rising SDA while SCL is high (STOP) clears `bus_busy_o` and `addr_match_o`. `bus_busy_o` never falls for any other reason.
- R4: A repeated START that arrives while the bus is busy keeps `bus_busy_o` at 1 and restarts address reception. A target that is addressed again acknowledges again.
- R5: The first byte after a START is shifted in MSB first on SCL rising edges. Bits 7..1 are compared with {DEV_CLASS, strap_i}, with the class code in bits 7..4. Bit 0 is the direction and is shown on `rw_o`: 0 means the controller writes, 1 means it reads.
- R6: When the address matches, `addr_match_o` is set and `sda_pd_no` is held at 0 during the ninth SCL pulse.
- R7: In a write transfer, each data byte (MSB first) is acknowledged in its ninth pulse. `wr_valid_o` goes high for exactly one clock with the byte on `wr_data_o`.
- R8: When the address does not match, SDA stays released and no strobe is raised until the next START.
- R9: In a read transfer, `rd_req_o` pulses for one clock when `rd_data_i` is loaded. The byte is driven MSB first. The pull-down is only ever switched on while SCL is low.
- R10: After a byte has been read, an ACK (SDA 0 in the ninth pulse) loads the next byte. A NACK (SDA 1) makes the block release SDA for the rest of the transfer.
- R11: SDA changes while SCL is low are neither conditions nor data. A bit is taken only at an SCL rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Strap pins forming the low address bits |
| rd_data_i | input | 8 | Byte to send in a read transfer |
| sda_pd_no | output | 1 | Active-low SDA pull-down enable |
| bus_busy_o | output | 1 | Bus busy flag |
| addr_match_o | output | 1 | Target is addressed in the current transfer |
| rw_o | output | 1 | Direction of the current transfer, 1 = read |
| wr_valid_o | output | 1 | One-cycle strobe for a received byte |
| wr_data_o | output | 8 | Received byte |
| rd_req_o | output | 1 | One-cycle strobe when rd_data_i is taken |

## Verification
The checker tests the following on every cycle:
- The busy flag rises after a START and drops only after a STOP.
- The pull-down is never asserted unless the target is addressed.
- The pull-down is never switched on while SCL is high.
- Write and read strobes last one cycle and agree with the latched direction.

Some behaviour only shows up in the bench scenarios, because it depends on a whole transfer:
- Whether the address compare and the byte values come out right.
- That a non-matching address leaves the line untouched.
- That a repeated START re-addresses the target.
- That a NACK silences the read path.
- That SDA wiggles during SCL low do not corrupt data.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    // idle bus is high, so reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], raw_i[g]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sync_q[STAGES-1];
    assign prev_o[g] = prev_q;
    assign rise_o[g] = sync_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_lvl_i,
  input  logic scl_prev_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic scl_held;
  logic busy_q;

  assign scl_held = scl_lvl_i & scl_prev_i;
  assign start_o  = scl_held & sda_fall_i;
  assign stop_o   = scl_held & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (stop_o)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned CLASS_W = 4,
  parameter logic [CLASS_W-1:0] DEV_CLASS = 4'b1010,
  localparam int unsigned STRAP_W = ADDR_W - CLASS_W,
  localparam int unsigned CNT_W   = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               pd_en_o,
  output logic               match_o,
  output logic               rw_o,
  output logic               wr_valid_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               rd_req_o
);
  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              pd_q, match_q, rw_q, acked_q, wr_valid_q, rd_req_q;

  logic [DATA_W-1:0] shift_in;
  logic [ADDR_W-1:0] dev_addr;
  logic              last_bit;
  logic              addr_hit;

  assign shift_in = {sreg_q[DATA_W-2:0], sda_i};
  assign dev_addr = {DEV_CLASS, strap_i};
  assign last_bit = (cnt_q == CNT_W'(DATA_W-1));
  assign addr_hit = (shift_in[DATA_W-1 -: ADDR_W] == dev_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sreg_q     <= '0;
      wr_data_q  <= '0;
      pd_q       <= 1'b0;
      match_q    <= 1'b0;
      rw_q       <= 1'b0;
      acked_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
        match_q <= 1'b0;
        acked_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
        match_q <= 1'b0;
        acked_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sreg_q <= shift_in;
              cnt_q  <= cnt_q + 1'b1;
              if (last_bit) begin
                cnt_q <= '0;
                if (addr_hit) begin
                  match_q <= 1'b1;
                  rw_q    <= shift_in[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_SKIP;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            // first SCL fall: pull low; second fall: ninth pulse done
            if (scl_fall_i) begin
              if (!pd_q) begin
                pd_q <= 1'b1;
              end else if (state_q == ST_WR_ACK || !rw_q) begin
                pd_q    <= 1'b0;
                state_q <= ST_WR;
              end else begin
                sreg_q   <= rd_data_i;
                rd_req_q <= 1'b1;
                pd_q     <= ~rd_data_i[DATA_W-1];
                cnt_q    <= '0;
                state_q  <= ST_RD;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sreg_q <= shift_in;
              cnt_q  <= cnt_q + 1'b1;
              if (last_bit) begin
                cnt_q      <= '0;
                wr_data_q  <= shift_in;
                wr_valid_q <= 1'b1;
                state_q    <= ST_WR_ACK;
              end
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (last_bit) begin
                pd_q    <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_RD_ACK;
              end else begin
                cnt_q  <= cnt_q + 1'b1;
                sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
                pd_q   <= ~sreg_q[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              acked_q <= ~sda_i;
            end else if (scl_fall_i) begin
              acked_q <= 1'b0;
              if (acked_q) begin
                sreg_q   <= rd_data_i;
                rd_req_q <= 1'b1;
                pd_q     <= ~rd_data_i[DATA_W-1];
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pd_en_o    = pd_q;
  assign match_o    = match_q;
  assign rw_o       = rw_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_data_o  = wr_data_q;
  assign rd_req_o   = rd_req_q;
endmodule

// File: rtl/i2c_target_fe.sv
module i2c_target_fe #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned CLASS_W     = 4,
  parameter logic [CLASS_W-1:0] DEV_CLASS = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STRAP_W    = ADDR_W - CLASS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sda_pd_no,
  output logic               bus_busy_o,
  output logic               addr_match_o,
  output logic               rw_o,
  output logic               wr_valid_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               rd_req_o
);
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [1:0] lvl, prev, rise, fall;
  logic       scl_lvl, sda_lvl;
  logic       start_det, stop_det;
  logic       pd_en;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .prev_o (prev),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl = lvl[IDX_SCL];
  assign sda_lvl = lvl[IDX_SDA];

  i2c_cond_det u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (scl_lvl),
    .scl_prev_i (prev[IDX_SCL]),
    .sda_rise_i (rise[IDX_SDA]),
    .sda_fall_i (fall[IDX_SDA]),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .busy_o     (bus_busy_o)
  );

  i2c_tgt_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLASS_W(CLASS_W), .DEV_CLASS(DEV_CLASS)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (rise[IDX_SCL]),
    .scl_fall_i (fall[IDX_SCL]),
    .sda_i      (sda_lvl),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data_i),
    .pd_en_o    (pd_en),
    .match_o    (addr_match_o),
    .rw_o       (rw_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o)
  );

  assign sda_pd_no = ~pd_en;
endmodule

// File: rtl/i2c_target_fe_chk.sv
module i2c_target_fe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_lvl,
  input logic start_det,
  input logic stop_det,
  input logic bus_busy_o,
  input logic sda_pd_no,
  input logic addr_match_o,
  input logic rw_o,
  input logic wr_valid_o,
  input logic rd_req_o
);
  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> bus_busy_o);

  a_r3_free_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!bus_busy_o && !addr_match_o));

  a_r3_busy_drop_needs_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_busy_o) |-> $past(stop_det));

  a_r4_restart_keeps_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && bus_busy_o) |=> bus_busy_o);

  a_r8_pd_only_when_addressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_pd_no |-> addr_match_o);

  a_r9_pd_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pd_no) |-> !scl_lvl);

  a_r7_wr_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r7_wr_strobe_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (addr_match_o && !rw_o));

  a_r9_rd_strobe_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (addr_match_o && rw_o));

  a_r9_rd_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
endmodule

bind i2c_target_fe i2c_target_fe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_lvl      (scl_lvl),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .bus_busy_o   (bus_busy_o),
  .sda_pd_no    (sda_pd_no),
  .addr_match_o (addr_match_o),
  .rw_o         (rw_o),
  .wr_valid_o   (wr_valid_o),
  .rd_req_o     (rd_req_o)
);

// File: tb/test_i2c_target_fe.sv
module test_i2c_target_fe;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] rd_data = 8'h00;
  logic       sda_pd_no, bus_busy, addr_match, rw, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic       sda_line;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, pd_low_cnt = 0;
  logic [7:0] wr_last = 8'h00;
  logic watch_busy = 1'b0, busy_drop = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & sda_pd_no;

  i2c_target_fe i_i2c_target_fe (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .rd_data_i(rd_data), .sda_pd_no(sda_pd_no),
    .bus_busy_o(bus_busy), .addr_match_o(addr_match), .rw_o(rw),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .rd_req_o(rd_req)
  );

  always @(negedge clk) begin
    if (wr_valid) begin wr_cnt++; wr_last = wr_data; end
    if (rd_req) rd_cnt++;
    if (!sda_pd_no) pd_low_cnt++;
    if (watch_busy && !bus_busy) busy_drop = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, input bit wiggle);
    if (wiggle) begin sda_m = ~b; wq(); sda_m = b; wq(); sda_m = ~b; wq(); end
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, input bit wiggle, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i], wiggle);
    recv_bit(ack);
  endtask

  task automatic read_byte(output logic [7:0] d, input logic ack_bit);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(ack_bit, 1'b0);
  endtask

  task automatic t_reset();
    chk(sda_pd_no == 1'b1, "R1 sda released", sda_pd_no, 1);
    chk(bus_busy == 1'b0, "R1 bus free", bus_busy, 0);
    chk(addr_match == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0,
        "R1 strobes low", {addr_match, wr_valid, rd_req}, 0);
  endtask

  task automatic t_start_stop();
    bus_start();
    chk(bus_busy == 1'b1, "R2 busy after start", bus_busy, 1);
    bus_stop(); wq();
    chk(bus_busy == 1'b0, "R3 free after stop", bus_busy, 0);
  endtask

  task automatic t_write();
    logic ack;
    int w0;
    w0 = wr_cnt;
    bus_start();
    write_byte(8'hAA, 1'b0, ack);
    chk(ack == 1'b0, "R6 address ack", ack, 0);
    chk(addr_match == 1'b1 && rw == 1'b0, "R5 write direction", {addr_match, rw}, 2);
    write_byte(8'h3C, 1'b0, ack);
    chk(ack == 1'b0, "R7 data ack", ack, 0);
    chk(wr_cnt == w0 + 1 && wr_last == 8'h3C, "R7 first byte", wr_last, 8'h3C);
    write_byte(8'hC5, 1'b1, ack);
    chk(ack == 1'b0 && wr_cnt == w0 + 2 && wr_last == 8'hC5, "R11 wiggle byte", wr_last, 8'hC5);
    bus_stop(); wq();
    chk(addr_match == 1'b0 && bus_busy == 1'b0, "R3 stop clears match", {addr_match, bus_busy}, 0);
  endtask

  task automatic t_no_match();
    logic ack;
    int w0, p0;
    w0 = wr_cnt; p0 = pd_low_cnt;
    bus_start();
    write_byte(8'hAC, 1'b0, ack);
    chk(ack == 1'b1, "R8 no ack on mismatch", ack, 1);
    write_byte(8'h00, 1'b0, ack);
    chk(ack == 1'b1 && wr_cnt == w0, "R8 data ignored", wr_cnt - w0, 0);
    chk(pd_low_cnt == p0 && addr_match == 1'b0, "R8 line untouched", pd_low_cnt - p0, 0);
    bus_stop(); wq();
  endtask

  task automatic t_strap();
    logic ack;
    strap = 3'b110;
    bus_start();
    write_byte(8'hAC, 1'b0, ack);
    chk(ack == 1'b0, "R5 strap address match", ack, 0);
    bus_stop(); wq();
    strap = 3'b101;
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    int r0, p0;
    r0 = rd_cnt;
    rd_data = 8'hC3;
    bus_start();
    write_byte(8'hAB, 1'b0, ack);
    chk(ack == 1'b0 && rw == 1'b1, "R5 read direction", {ack, rw}, 1);
    chk(rd_cnt == r0 + 1, "R9 first fetch", rd_cnt - r0, 1);
    rd_data = 8'h5A;
    read_byte(d, 1'b0);
    chk(d == 8'hC3, "R9 first read byte", d, 8'hC3);
    chk(rd_cnt == r0 + 2, "R10 ack fetches next", rd_cnt - r0, 2);
    rd_data = 8'hFF;
    read_byte(d, 1'b1);
    chk(d == 8'h5A, "R9 second read byte", d, 8'h5A);
    rd_data = 8'h00;
    p0 = pd_low_cnt;
    read_byte(d, 1'b1);
    chk(d == 8'hFF && pd_low_cnt == p0 && rd_cnt == r0 + 2, "R10 silent after nack", d, 8'hFF);
    bus_stop(); wq();
  endtask

  task automatic t_restart();
    logic ack;
    int w0;
    w0 = wr_cnt;
    bus_start();
    write_byte(8'hAA, 1'b0, ack);
    write_byte(8'h81, 1'b0, ack);
    watch_busy = 1'b1;
    bus_start();
    write_byte(8'hAB, 1'b0, ack);
    watch_busy = 1'b0;
    chk(busy_drop == 1'b0, "R4 busy held across restart", busy_drop, 0);
    chk(ack == 1'b0 && rw == 1'b1 && addr_match == 1'b1, "R4 readdressed", {ack, rw, addr_match}, 3);
    chk(wr_cnt == w0 + 1 && wr_last == 8'h81, "R7 byte before restart", wr_last, 8'h81);
    begin
      logic [7:0] d;
      read_byte(d, 1'b1);
    end
    bus_stop(); wq();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_start_stop();
    t_write();
    t_no_match();
    t_strap();
    t_read();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule